// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a per-core countdown timer that runs from the bus clock and produces interrupt requests. Software programs three registers through a simple write port. The first is a divide setting, which chooses how many bus clocks pass between count steps. The second is a start value, which is loaded into a live down-counter. The third is a vector-table entry, which holds the 8-bit interrupt vector, a mask flag and a one-shot/periodic mode flag. The live count is always visible on an output port.

When the counter steps from one to zero, the block emits a one-clock request that carries the programmed vector. In one-shot mode the counter then rests at zero. In periodic mode it reloads the start value and keeps running. A masked timer still counts and reloads, but it raises no request.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, `cur_count` is 0, `irq_valid` is low, the divide code is 000 and the vector-table entry is masked, one-shot, vector 0. A timer started without writing the entry therefore counts but raises no request.
- R2: The divide code (write select 2, data bits 2:0) sets the step interval n: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1 bus clock. The count decreases by one every n clocks. Writing the code restarts the step phase.
- R3: A write with select 1 loads the start value into the counter and restarts the step phase. `cur_count` shows the value from the next clock on, and shows N-floor(k/n) k clocks after the write.
- R4: In one-shot mode (entry bit 17 = 0), exactly one request is raised, N*n clocks after the start write. The count then stays at 0.
- R5: In periodic mode (entry bit 17 = 1), a request is raised every N*n clocks. On the step that would reach zero, the counter reloads N.
- R6: When entry bit 16 (mask) is 1, the counter still steps and reloads, but `irq_valid` stays low.
- R7: Writing a start value of 0 stops the timer with `cur_count` 0, and no request follows.
- R8: A request is `irq_valid` high for a single clock, with `irq_vector` equal to entry bits 7:0 (write select 0).
- R9: Writing a new start value while a countdown is running discards the old countdown. Only the new one produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 vector entry, 1 start value, 2 divide code |
| wr_data | input | DATA_W | Write data |
| cur_count | output | CNT_W | Live count value |
| irq_valid | output | 1 | One-clock interrupt request |
| irq_vector | output | VEC_W | Vector carried with the request |

## Verification
A wrong step phase or a wrong divide decode shows up on `cur_count` within one step interval. It also moves the request by whole multiples of n clocks, so every request is compared against the exact clock number predicted from the start write. A stale run flag or a stale reload value shows up one period later, as a missing, extra or early pulse. Mask and restart errors show up as requests that the scoreboard never expected, in the clock where the old countdown would have expired.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } vec_entry_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] shift;
  logic [PRE_W:0]    lim_w;
  logic [PRE_W-1:0]  lim;
  logic [PRE_W-1:0]  pcnt_q;

  always_comb begin
    shift  = (code_i == {CODE_W{1'b1}}) ? '0 : code_i + 1'b1;
    lim_w  = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
    lim    = lim_w[PRE_W-1:0];
    tick_o = (pcnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  pcnt_q <= '0;
    else if (tick_o)   pcnt_q <= '0;
    else               pcnt_q <= pcnt_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && lim != '0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q;
  logic             run_q;

  assign expire_o = tick_i && run_q && !load_i && (count_o == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      init_q  <= '0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      count_o <= load_val_i;
      init_q  <= load_val_i;
      run_q   <= |load_val_i;
    end else if (tick_i && run_q) begin
      if (count_o == CNT_W'(1)) begin
        if (periodic_i) count_o <= init_q;
        else begin
          count_o <= '0;
          run_q   <= 1'b0;
        end
      end else begin
        count_o <= count_o - 1'b1;
      end
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_o == $past(load_val_i)));
  // R7
  zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_val_i == '0) |=> (!run_q && count_o == '0));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int VEC_W      = 8,
  parameter int DIV_CODE_W = 3,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cur_count,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0]      vec_q;
  logic                  masked_q;
  logic                  periodic_q;
  logic [DIV_CODE_W-1:0] div_q;
  logic                  load, div_wr, tick, expire;

  assign load   = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);
  assign div_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q      <= '0;
      masked_q   <= 1'b1;
      periodic_q <= 1'b0;
      div_q      <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_VEC) begin
        vec_q      <= wr_data[VEC_W-1:0];
        masked_q   <= wr_data[MASK_BIT];
        periodic_q <= wr_data[MODE_BIT];
      end
      if (div_wr) div_q <= wr_data[DIV_CODE_W-1:0];
    end
  end

  tmr_prescale #(.CODE_W(DIV_CODE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (load || div_wr),
    .code_i (div_q),
    .tick_o (tick)
  );

  tmr_down #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (wr_data[CNT_W-1:0]),
    .tick_i     (tick),
    .periodic_i (periodic_q),
    .count_o    (cur_count),
    .expire_o   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire && !masked_q;
      if (expire) irq_vector <= vec_q;
    end
  end

  // R6
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    masked_q |=> !irq_valid);
  // R8
  req_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !masked_q) |=> (irq_valid && irq_vector == $past(vec_q)));
endmodule

// File: tb/irq_countdown_timer_bench.sv
module irq_countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_cyc[$];
  int exp_vec[$];
  int tw;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tw = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_irq(input int c, input int v);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL R4/R5 missing request actual=none expected cycle %0d", exp_cyc[0]);
        void'(exp_cyc.pop_front());
        void'(exp_vec.pop_front());
      end
      if (irq_valid) begin
        if (exp_cyc.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R6/R7/R9 unexpected request actual=cycle %0d expected=none", cyc);
        end else begin
          chk("R4/R5 request cycle", cyc, exp_cyc.pop_front());
          chk("R8 vector", irq_vector, exp_vec.pop_front());
        end
      end
    end
  end

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cur_count, 0);
    chk("R1 irq", irq_valid, 0);
    // R1 default masked: counts, no request
    wr(2'd2, 32'd7);
    wr(2'd1, 32'd5);
    wait_until(tw + 2); chk("R1 counting", cur_count, 3);
    wait_until(tw + 12); chk("R1/R4 rest at zero", cur_count, 0);

    // R4 one-shot, n=2 (code 000), vector 0x41
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'd4);
    expect_irq(tw + 8, 8'h41);
    wait_until(tw + 3); chk("R2/R3 step n=2", cur_count, 3);
    wait_until(tw + 5); chk("R2 step n=2", cur_count, 2);
    wait_until(tw + 25); chk("R4 stays zero", cur_count, 0);
    chk("R4 queue drained", exp_cyc.size(), 0);

    // R5 periodic, n=4 (code 001), vector 0x7A
    wr(2'd2, 32'd1);
    wr(2'd0, 32'h0002_007A);
    wr(2'd1, 32'd3);
    expect_irq(tw + 12, 8'h7A);
    expect_irq(tw + 24, 8'h7A);
    expect_irq(tw + 36, 8'h7A);
    wait_until(tw + 4); chk("R2 step n=4", cur_count, 2);
    wait_until(tw + 40);
    // R7 zero write stops
    wr(2'd1, 32'd0);
    chk("R7 stopped", cur_count, 0);
    wait_until(tw + 30); chk("R7 still zero", cur_count, 0);

    // R6 masked periodic, n=1
    wr(2'd2, 32'd7);
    wr(2'd0, 32'h0003_0055);
    wr(2'd1, 32'd6);
    wait_until(tw + 2); chk("R6 counting", cur_count, 4);
    wait_until(tw + 6); chk("R5/R6 reload", cur_count, 6);
    wait_until(tw + 7); chk("R6 after reload", cur_count, 5);
    wait_until(tw + 20);
    wr(2'd1, 32'd0);

    // R9 restart during countdown
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'd10);
    wait_until(tw + 4);
    wr(2'd1, 32'd3);
    chk("R9 reload", cur_count, 3);
    expect_irq(tw + 3, 8'h10);
    wait_until(tw + 20);

    // R2 divide by 128 (code 110)
    wr(2'd2, 32'd6);
    wr(2'd1, 32'd2);
    expect_irq(tw + 256, 8'h10);
    wait_until(tw + 127); chk("R2 n=128 hold", cur_count, 2);
    wait_until(tw + 128); chk("R2 n=128 step", cur_count, 1);
    wait_until(tw + 270); chk("R4 end", cur_count, 0);
    chk("R9/R2 queue drained", exp_cyc.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule